// File: doc/BRIEF.md
# Transition-Compressing Timing Capture

This block is the acquisition core of an on-chip timing analyser. It watches up to `NCH` asynchronous logic lines and samples them on a strobe that its own divider makes from the system clock. The device under test plays no part in when samples are taken. An arm strobe loads the configuration and readies the block. Nothing is stored until the trigger input goes high. From then on, records go into an internal capture memory until that memory is full.

Three capture modes are available. Raw mode stores the whole sampled word on every strobe. Compressed mode stores one record for each channel that changes level. The record holds the number of strobes since that channel last changed, which makes the capture window far longer than raw storage when activity is sparse. Glitch mode works like compressed mode but keeps a transition only when its interval is shorter than a programmable threshold. This isolates runt pulses and hold violations. A host reads back the records through a synchronous read port and a fill count.

Top module: `edge_log_capture`

## Requirements
- R1: On `arm_i`, the block latches mode, rate and threshold, clears the fill count, the done flag and every interval counter, and enters the armed state. `trig_i` outside the armed state has no effect. While armed, no record is stored. The trigger cycle starts the capture. Mode encoding: 0 raw, 2 glitch, 1 or 3 compressed.
- R2: Channel inputs pass through a two-flop synchronizer. The sample strobe period is max(`cfg_rate_i`+1, `NCH`) clocks. The first strobe comes one full period after the trigger cycle.
- R3: In raw mode, every strobe writes one record whose low `NCH` bits are the synchronized sample, with all other bits zero.
- R4: In compressed mode, each channel whose level differs from its level at the previous strobe stores one record. Bits [CNT_W-1:0] hold the interval, bit CNT_W holds the new level, the next IDX_W bits hold the channel index, and the top bit is 0. The interval is the number of strobes since that channel's previous transition, or since the trigger if it has none.
- R5: In glitch mode, a transition is stored only when its interval is strictly less than the threshold. A threshold of 0 stores nothing.
- R6: When a channel's interval count reaches all ones at a strobe with no transition, an overflow record is stored and the count restarts from zero. This record has the top bit 1, the channel index, the current level and an all-ones interval. In glitch mode, overflow records are not stored.
- R7: Records raised at the same strobe are written one per clock, lowest channel index first, at consecutive addresses.
- R8: `fill_o` counts the stored records. At `DEPTH` records, capture stops, `done_o` rises and stays high, and later activity stores nothing.
- R9: An arm strobe during a capture or after done restarts the block. Intervals of the new capture are measured from its own trigger.
- R10: `rd_data_o` presents the record at `rd_addr_i` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode_i | input | 2 | Capture mode, latched on arm |
| cfg_rate_i | input | 16 | Divider setting, latched on arm |
| cfg_thresh_i | input | CNT_W | Glitch threshold in strobes, latched on arm |
| arm_i | input | 1 | Arm / restart strobe |
| trig_i | input | 1 | Trigger condition |
| ch_i | input | NCH | Asynchronous channel inputs |
| rd_addr_i | input | log2(DEPTH) | Capture memory read address |
| rd_data_o | output | REC_W | Record read back |
| fill_o | output | log2(DEPTH)+1 | Number of stored records |
| armed_o | output | 1 | Waiting for trigger |
| running_o | output | 1 | Capture in progress |
| done_o | output | 1 | Memory full |

## Verification
The collision of interest is between draining queued transition records and the next sample strobe. At the minimum period of `NCH` clocks, a strobe where every channel flips queues `NCH` records. The last of these is written in the same cycle that the next strobe raises new ones. The bench forces all channels to flip together with the divider at its floor. It also sets the divider below the floor, so the clamp itself is exercised. It then compares every stored record, in order and in address, against a strobe-by-strobe model built from the requirements. A lost, duplicated or reordered record shows up as a mismatch.

// File: rtl/edge_log_pkg.sv
package edge_log_pkg;

    localparam int RATE_W = 16;

    typedef enum logic [1:0] {
        MODE_RAW    = 2'd0,
        MODE_DELTA  = 2'd1,
        MODE_GLITCH = 2'd2,
        MODE_DELTA2 = 2'd3
    } cap_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_RUN,
        ST_DONE
    } cap_state_e;

    typedef struct packed {
        cap_mode_e         mode;
        logic [RATE_W-1:0] rate;
    } cap_cfg_t;

    function automatic int max_i(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/edge_log_sync.sv
module edge_log_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta;
        logic stable;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta   <= 1'b0;
                stable <= 1'b0;
            end else begin
                meta   <= d_i[i];
                stable <= meta;
            end
        end
        assign q_o[i] = stable;
    end
endmodule

// File: rtl/edge_log_tick.sv
module edge_log_tick #(
    parameter int RATE_W = 16,
    parameter int MIN_P  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              en,
    input  logic [RATE_W-1:0] rate_i,
    output logic              strobe_o
);
    localparam logic [RATE_W-1:0] FLOOR = RATE_W'(MIN_P - 1);

    logic [RATE_W-1:0] cnt;
    logic [RATE_W-1:0] last;

    assign last     = (rate_i < FLOOR) ? FLOOR : rate_i;
    assign strobe_o = en && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= strobe_o ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/edge_log_chan.sv
module edge_log_chan #(
    parameter int IDX   = 0,
    parameter int IDX_W = 3,
    parameter int CNT_W = 16,
    parameter int REC_W = 21
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             strobe_i,
    input  logic             lvl_i,
    input  logic             emit_en_i,
    input  logic             glitch_i,
    input  logic [CNT_W-1:0] thresh_i,
    input  logic             grant_i,
    output logic             pend_o,
    output logic [REC_W-1:0] rec_o
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] nxt;
    logic             prev;

    assign nxt = cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt    <= '0;
            prev   <= lvl_i;
            pend_o <= 1'b0;
            rec_o  <= '0;
        end else begin
            if (grant_i) pend_o <= 1'b0;
            if (strobe_i) begin
                if (lvl_i != prev) begin
                    prev <= lvl_i;
                    cnt  <= '0;
                    if (emit_en_i && (!glitch_i || nxt < thresh_i)) begin
                        pend_o <= 1'b1;
                        rec_o  <= REC_W'({1'b0, IDX_W'(IDX), lvl_i, nxt});
                    end
                end else if (nxt == CNT_TOP) begin
                    cnt <= '0;
                    if (emit_en_i && !glitch_i) begin
                        pend_o <= 1'b1;
                        rec_o  <= REC_W'({1'b1, IDX_W'(IDX), prev, nxt});
                    end
                end else begin
                    cnt <= nxt;
                end
            end
        end
    end
endmodule

// File: rtl/edge_log_mem.sv
module edge_log_mem #(
    parameter int W      = 21,
    parameter int DEPTH  = 1024,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [W-1:0]      wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [W-1:0]      rdata_o
);
    logic [W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) store[waddr_i] <= wdata_i;
        rdata_o <= store[raddr_i];
    end
endmodule

// File: rtl/edge_log_capture.sv
module edge_log_capture
    import edge_log_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int CNT_W = 16,
    parameter int DEPTH = 1024,
    localparam int IDX_W  = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int REC_W  = max_i(2 + IDX_W + CNT_W, NCH),
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int FILL_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cfg_mode_i,
    input  logic [RATE_W-1:0] cfg_rate_i,
    input  logic [CNT_W-1:0]  cfg_thresh_i,
    input  logic              arm_i,
    input  logic              trig_i,
    input  logic [NCH-1:0]    ch_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [REC_W-1:0]  rd_data_o,
    output logic [FILL_W-1:0] fill_o,
    output logic              armed_o,
    output logic              running_o,
    output logic              done_o
);
    localparam logic [FILL_W-1:0] LAST_SLOT = FILL_W'(DEPTH - 1);

    cap_state_e       state;
    cap_cfg_t         cfg_q;
    logic [CNT_W-1:0] thr_q;
    logic [NCH-1:0]   ch_s;
    logic             start;
    logic             clr;
    logic             strobe;
    logic             is_raw;
    logic             is_glitch;
    logic [NCH-1:0]   pend;
    logic [NCH-1:0]   grant;
    logic [REC_W-1:0] rec_arr [NCH];
    logic [REC_W-1:0] sel_rec;
    logic [REC_W-1:0] raw_rec;
    logic [REC_W-1:0] wr_data;
    logic             wr_en;

    assign armed_o   = (state == ST_ARMED);
    assign running_o = (state == ST_RUN);
    assign done_o    = (state == ST_DONE);
    assign start     = armed_o && trig_i && !arm_i;
    assign clr       = arm_i || start;
    assign is_raw    = (cfg_q.mode == MODE_RAW);
    assign is_glitch = (cfg_q.mode == MODE_GLITCH);

    edge_log_sync #(.W(NCH)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (ch_i),
        .q_o (ch_s)
    );

    edge_log_tick #(.RATE_W(RATE_W), .MIN_P(NCH)) u_tick (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .en       (running_o),
        .rate_i   (cfg_q.rate),
        .strobe_o (strobe)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        edge_log_chan #(
            .IDX   (i),
            .IDX_W (IDX_W),
            .CNT_W (CNT_W),
            .REC_W (REC_W)
        ) u_chan (
            .clk       (clk),
            .rst       (rst),
            .clr       (clr),
            .strobe_i  (strobe),
            .lvl_i     (ch_s[i]),
            .emit_en_i (!is_raw),
            .glitch_i  (is_glitch),
            .thresh_i  (thr_q),
            .grant_i   (grant[i]),
            .pend_o    (pend[i]),
            .rec_o     (rec_arr[i])
        );
    end

    // lowest pending channel wins the single write port
    assign grant = running_o ? (pend & (~pend + 1'b1)) : '0;

    always_comb begin
        sel_rec = '0;
        for (int i = 0; i < NCH; i++) begin
            if (grant[i]) sel_rec |= rec_arr[i];
        end
        raw_rec = '0;
        raw_rec[NCH-1:0] = ch_s;
    end

    assign wr_en   = running_o && (is_raw ? strobe : (|grant));
    assign wr_data = is_raw ? raw_rec : sel_rec;

    edge_log_mem #(.W(REC_W), .DEPTH(DEPTH)) u_mem (
        .clk     (clk),
        .we_i    (wr_en),
        .waddr_i (fill_o[ADDR_W-1:0]),
        .wdata_i (wr_data),
        .raddr_i (rd_addr_i),
        .rdata_o (rd_data_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            fill_o <= '0;
            cfg_q  <= '0;
            thr_q  <= '0;
        end else if (arm_i) begin
            state      <= ST_ARMED;
            fill_o     <= '0;
            cfg_q.mode <= cap_mode_e'(cfg_mode_i);
            cfg_q.rate <= cfg_rate_i;
            thr_q      <= cfg_thresh_i;
        end else begin
            case (state)
                ST_ARMED: if (trig_i) state <= ST_RUN;
                ST_RUN: begin
                    if (wr_en) begin
                        fill_o <= fill_o + 1'b1;
                        if (fill_o == LAST_SLOT) state <= ST_DONE;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/edge_log_checker.sv
module edge_log_checker #(
    parameter int NCH    = 8,
    parameter int DEPTH  = 1024,
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              arm_i,
    input logic              armed,
    input logic              running,
    input logic              done,
    input logic [ADDR_W:0]   fill,
    input logic              wr_en,
    input logic [NCH-1:0]    grant,
    input logic [NCH-1:0]    pend
);
    localparam logic [ADDR_W:0] FULL = (ADDR_W + 1)'(DEPTH);

    assert_fill_bound_R8: assert property (@(posedge clk) disable iff (rst)
        fill <= FULL);

    assert_arm_clears_R1: assert property (@(posedge clk) disable iff (rst)
        arm_i |=> (fill == '0) && !done && armed);

    assert_no_write_idle_R1: assert property (@(posedge clk) disable iff (rst)
        !running |-> !wr_en);

    assert_single_grant_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    assert_lowest_first_R7: assert property (@(posedge clk) disable iff (rst)
        (|grant) |-> (((grant - 1'b1) & pend) == '0));

    assert_done_holds_R8: assert property (@(posedge clk) disable iff (rst)
        (done && !arm_i) |=> done);

    assert_fill_step_R8: assert property (@(posedge clk) disable iff (rst)
        !arm_i |=> (fill == $past(fill)) || (fill == $past(fill) + 1'b1));

    assert_done_when_full_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (fill == FULL));
endmodule

bind edge_log_capture edge_log_checker #(
    .NCH    (NCH),
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .arm_i   (arm_i),
    .armed   (armed_o),
    .running (running_o),
    .done    (done_o),
    .fill    (fill_o),
    .wr_en   (wr_en),
    .grant   (grant),
    .pend    (pend)
);

// File: tb/edge_log_capture_bench.sv
module edge_log_capture_bench;
    localparam int NCH = 8;
    localparam int CW  = 8;
    localparam int DEP = 1024;
    localparam int RW  = 2 + 3 + CW;
    localparam int TOPV = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    cfg_mode = '0;
    logic [15:0]   cfg_rate = '0;
    logic [CW-1:0] cfg_thr = '0;
    logic          arm = 1'b0;
    logic          trig = 1'b0;
    logic [7:0]    ch = '0;
    logic [9:0]    rd_addr = '0;
    logic [RW-1:0] rd_data;
    logic [10:0]   fill;
    logic          armed, running, done;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int c_a = 0;
    bit finished = 0;

    logic [7:0]    pat [0:1200];
    logic [RW-1:0] exp_rec [0:DEP-1];
    int            exp_n;

    edge_log_capture #(.NCH(NCH), .CNT_W(CW), .DEPTH(DEP)) u_edge_log_capture (
        .clk(clk), .rst(rst), .cfg_mode_i(cfg_mode), .cfg_rate_i(cfg_rate),
        .cfg_thresh_i(cfg_thr), .arm_i(arm), .trig_i(trig), .ch_i(ch),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data), .fill_o(fill),
        .armed_o(armed), .running_o(running), .done_o(done)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [RW-1:0] mk(input bit ovf, input int idx, input bit lvl, input int iv);
        return {ovf, 3'(idx), lvl, CW'(iv)};
    endfunction

    function automatic int period(input int r);
        return (r + 1 < NCH) ? NCH : r + 1;
    endfunction

    // strobe-by-strobe expectation from the requirements
    task automatic model(input int mode, input int thr, input int ns, input int m);
        int last [NCH];
        bit lvl [NCH];
        logic [7:0] v;
        exp_n = 0;
        for (int c = 0; c < NCH; c++) begin
            last[c] = 0;
            lvl[c]  = pat[0][c];
        end
        for (int s = 1; s <= m; s++) begin
            v = (s <= ns) ? pat[s] : pat[ns];
            if (mode == 0) begin
                if (exp_n < DEP) begin exp_rec[exp_n] = RW'(v); exp_n++; end
            end else begin
                for (int c = 0; c < NCH; c++) begin
                    if (v[c] != lvl[c]) begin
                        lvl[c] = v[c];
                        if ((mode != 2 || (s - last[c]) < thr) && exp_n < DEP) begin
                            exp_rec[exp_n] = mk(1'b0, c, v[c], s - last[c]);
                            exp_n++;
                        end
                        last[c] = s;
                    end else if (s - last[c] == TOPV) begin
                        last[c] = s;
                        if (mode != 2 && exp_n < DEP) begin
                            exp_rec[exp_n] = mk(1'b1, c, lvl[c], TOPV);
                            exp_n++;
                        end
                    end
                end
            end
        end
    endtask

    task automatic wait_until(input int ofs);
        while (cyc < c_a + ofs) @(negedge clk);
    endtask

    task automatic do_arm(input int mode, input int rate, input int thr);
        @(negedge clk);
        cfg_mode = 2'(mode);
        cfg_rate = 16'(rate);
        cfg_thr  = CW'(thr);
        arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
    endtask

    task automatic fire;
        @(negedge clk);
        trig = 1'b1;
        do @(negedge clk); while (!running);
        c_a  = cyc;
        trig = 1'b0;
    endtask

    task automatic gen_pat(input int ns, input int odds, input int quiet_mask);
        pat[0] = 8'($urandom);
        for (int k = 1; k <= ns; k++) begin
            pat[k] = pat[k-1];
            for (int c = 0; c < NCH; c++)
                if (!quiet_mask[c] && ($urandom % odds) == 0) pat[k][c] = ~pat[k][c];
        end
    endtask

    task automatic compare(input string tag, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rd_addr = 10'(i);
            @(negedge clk);
            check(tag, 32'(rd_data), 32'(exp_rec[i]));
        end
    endtask

    task automatic capture(input int mode, input int rate, input int thr,
                           input int ns, input string tag);
        int p;
        int m;
        p = period(rate);
        m = ns + 2;
        do_arm(mode, rate, thr);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            ch = 8'($urandom);
        end
        ch = pat[0];
        repeat (5) @(negedge clk);
        check("R1 nothing stored while armed", 32'(fill), 0);
        check("R1 armed flag", 32'(armed), 1);
        fire();
        for (int k = 1; k <= ns; k++) begin
            wait_until((k - 1) * p + p / 2);
            ch = pat[k];
        end
        model(mode, thr, ns, m);
        if (mode == 0) wait_until(m * p + p / 2);
        else           wait_until((m + 1) * p);
        check({tag, " fill R8"}, 32'(fill), 32'(exp_n));
        compare({tag, " R10"}, exp_n);
    endtask

    initial begin
        void'($urandom(32'd20250611));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset fill", 32'(fill), 0);
        check("R1 reset flags", {29'd0, armed, running, done}, 0);

        // trigger without arm is ignored
        trig = 1'b1;
        repeat (3) @(negedge clk);
        trig = 1'b0;
        check("R1 trigger while idle", {30'd0, running, armed}, 0);

        // raw, divider below floor and above floor
        gen_pat(40, 2, 0);
        capture(0, 2, 0, 40, "R2 R3 raw floor");
        gen_pat(20, 2, 0);
        capture(0, 39, 0, 20, "R2 R3 raw slow");

        // compressed: all channels flip at strobe 5, two channels quiet for overflow
        gen_pat(300, 8, 8'hC0);
        for (int k = 5; k <= 300; k++) pat[k][7:6] = ~pat[0][7:6];
        for (int k = 5; k <= 300; k++) pat[k][5:0] = pat[k][5:0] ^ 6'h3F;
        capture(1, 7, 0, 300, "R4 R6 R7 compressed");

        // glitch mode, threshold 5
        gen_pat(300, 3, 8'h80);
        capture(2, 7, 5, 300, "R5 R6 glitch");

        // glitch with threshold 0 keeps nothing
        gen_pat(50, 2, 0);
        capture(2, 7, 0, 50, "R5 zero threshold");

        // fill the memory in raw mode
        gen_pat(1100, 2, 0);
        capture(0, 7, 0, 1100, "R8 raw full");
        check("R8 done flag", 32'(done), 1);
        check("R8 stopped", 32'(running), 0);
        repeat (40) @(negedge clk);
        check("R8 no store after full", 32'(fill), DEP);

        do_arm(1, 7, 0);
        check("R9 rearm after done fill", 32'(fill), 0);
        check("R9 rearm after done flags", {30'd0, done, armed}, 1);

        // arm in the middle of a capture, then a fresh one
        ch = 8'h00;
        repeat (4) @(negedge clk);
        fire();
        for (int k = 1; k <= 20; k++) begin
            wait_until((k - 1) * 8 + 4);
            ch = 8'($urandom);
        end
        do_arm(3, 7, 0);
        check("R9 rearm mid capture fill", 32'(fill), 0);
        check("R9 rearm mid capture state", {30'd0, running, armed}, 1);
        gen_pat(30, 4, 0);
        capture(3, 7, 0, 30, "R9 R4 restart");

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog R8 actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule